// File: doc/BRIEF.md
# Threshold-Driven Receive FIFO Controller

This block sits between the byte stream recovered from a memory card's data lines and the system side that moves data into memory. Each accepted byte is stored in a 256-byte queue and also counted. When the count reaches a programmed threshold, the block emits a transfer-request pulse toward a DMA engine or CPU and raises a sticky interrupt flag. The system then drains the queue through a 32-bit word port and signals completion.

After a request goes out, the block stays in a pending condition but keeps accepting bytes. If the threshold is reached a second time before completion arrives, intake stops and the block waits. When completion arrives, it issues the next request at once and restarts the count. When the queue fills, the ready output drops so the card side holds its byte.

Top module: `rxq_ctrl`

## Requirements
- R1: After synchronous reset, empty is 1, full is 0, level is 0, xfer_req, req_pend and irq_flag are 0, and in_ready is 1.
- R2: rd_word shows the four oldest stored bytes, with the earliest byte in bits 7:0. A pulse on rd_en removes them only when level is at least 4. With fewer bytes stored, rd_en is ignored and level is unchanged.
- R3: A byte is stored when in_valid and in_ready are both high at a clock edge. Level then rises by one, and empty and full follow level.
- R4: With thr_sel at 0, every 32nd counted byte produces a request. xfer_req is high for exactly the one cycle that follows the edge that stored that byte.
- R5: With thr_sel at 1, the threshold is 64 bytes, and no request appears at the 32nd byte.
- R6: irq_flag sets with every request and stays set until a pulse on irq_clr. If a request and a clear arrive together, the flag stays set.
- R7: After a request, req_pend is high and bytes are still accepted and counted.
- R8: If the threshold is reached again while req_pend is high, in_ready goes low and no byte is stored. The next xfer_done then produces a request in the following cycle, restarts the count, and raises in_ready again.
- R9: An xfer_done that arrives while pending with the count below threshold clears req_pend and issues no request.
- R10: An xfer_done that arrives while req_pend is low has no effect: no request is issued and req_pend stays low.
- R11: When level equals 256, full is 1 and in_ready is 0, and a byte offered with in_valid is not stored.
- R12: A reset in mid-operation empties the queue and clears the pending state, the request and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Byte from the card data path |
| in_valid | input | 1 | in_byte holds a byte |
| in_ready | output | 1 | Block can store a byte this cycle |
| thr_sel | input | 1 | Threshold select: 0 means 32 bytes, 1 means 64 bytes |
| xfer_req | output | 1 | One-cycle transfer request pulse |
| req_pend | output | 1 | A request is outstanding |
| xfer_done | input | 1 | Completion from the DMA engine or CPU |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_flag |
| rd_en | input | 1 | Remove one word from the queue |
| rd_word | output | 32 | Oldest four bytes, earliest byte lowest |
| full | output | 1 | Queue holds 256 bytes |
| empty | output | 1 | Queue holds no byte |
| level | output | 9 | Number of bytes stored |

## Verification
The bench builds the block with its default parameters: a 256-entry queue, thresholds of 32 and 64, and little-endian lane order. With a 256-byte queue, filling to full takes only a few hundred cycles, so backpressure and wrap-around of both pointers are exercised in one run. With two thresholds, the bench can show that a request comes at the 64th byte and not at the 32nd. It can also drive the held state of the second threshold crossing, and then release that state with completion pulses until the queue is full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_HOLD = 2'd2
   } rxq_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH      = 256,
   parameter int WORD_BYTES = 4,
   parameter bit BIG_END    = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        push,
   input  logic [7:0]                  push_byte,
   input  logic                        pop,
   output logic [8*WORD_BYTES-1:0]     word,
   output logic                        full,
   output logic                        empty,
   output logic [$clog2(DEPTH+1)-1:0]  level
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH+1);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxq_store: DEPTH must be a power of two");
      end
      if ((DEPTH % WORD_BYTES) != 0) begin : g_bad_word
         $error("rxq_store: DEPTH must be a multiple of WORD_BYTES");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic [LW-1:0] cnt_q;
   logic          push_ok;
   logic          pop_ok;

   assign full    = (cnt_q == LW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign level   = cnt_q;
   assign push_ok = push && !full;
   assign pop_ok  = pop && (cnt_q >= LW'(WORD_BYTES));

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wptr <= wptr + AW'(1);
         if (pop_ok)  rptr <= rptr + AW'(WORD_BYTES);
         cnt_q <= cnt_q + LW'(push_ok) - (pop_ok ? LW'(WORD_BYTES) : LW'(0));
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= push_byte;
   end

   generate
      for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
         logic [AW-1:0] idx;
         assign idx = rptr + AW'(i);
         if (BIG_END) begin : g_be
            assign word[(WORD_BYTES-1-i)*8 +: 8] = mem[idx];
         end else begin : g_le
            assign word[i*8 +: 8] = mem[idx];
         end
      end
   endgenerate

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LW'(DEPTH));

   // R2
   short_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (pop && !push && cnt_q < LW'(WORD_BYTES)) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/rxq_reqfsm.sv
module rxq_reqfsm
   import rxq_pkg::*;
#(
   parameter int THR_LO = 32,
   parameter int THR_HI = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic cap,
   input  logic thr_sel,
   input  logic done,
   input  logic irq_clr,
   output logic stall,
   output logic xfer_req,
   output logic req_pend,
   output logic irq_flag
);
   localparam int CW = $clog2(THR_HI + 1);

   generate
      if (THR_LO < 2 || THR_HI < THR_LO) begin : g_bad_thr
         $error("rxq_reqfsm: need 2 <= THR_LO <= THR_HI");
      end
   endgenerate

   rxq_state_e  state, state_d;
   logic [CW:0] cnt, cnt_d;
   logic [CW:0] cnt_inc;
   logic [CW:0] thr;
   logic        hit;
   logic        req_d;

   assign thr     = thr_sel ? (CW+1)'(THR_HI) : (CW+1)'(THR_LO);
   assign cnt_inc = cnt + (CW+1)'(1);
   assign hit     = cap && (cnt_inc >= thr);

   always_comb begin
      state_d = state;
      cnt_d   = cap ? cnt_inc : cnt;
      req_d   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (hit) begin
               cnt_d   = '0;
               req_d   = 1'b1;
               state_d = ST_PEND;
            end
         end
         ST_PEND: begin
            if (done && hit) begin
               cnt_d = '0;
               req_d = 1'b1;
            end else if (done) begin
               state_d = ST_IDLE;
            end else if (hit) begin
               cnt_d   = thr;
               state_d = ST_HOLD;
            end
         end
         ST_HOLD: begin
            cnt_d = cnt;
            if (done) begin
               cnt_d   = '0;
               req_d   = 1'b1;
               state_d = ST_PEND;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         xfer_req <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         state    <= state_d;
         cnt      <= cnt_d;
         xfer_req <= req_d;
         if (req_d)        irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;
      end
   end

   assign stall    = (state == ST_HOLD);
   assign req_pend = (state != ST_IDLE);

   // R4
   req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_req |=> !xfer_req);

   // R6
   irq_set_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_req |-> irq_flag);

   // R8
   hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD && !done) |=> (state == ST_HOLD && $stable(cnt)));

   // R10
   idle_done_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && done && !cap) |=> (state == ST_IDLE && !xfer_req));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= (CW+1)'(THR_HI));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH      = 256,
   parameter int THR_LO     = 32,
   parameter int THR_HI     = 64,
   parameter int WORD_BYTES = 4,
   parameter bit BIG_END    = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [7:0]                  in_byte,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic                        thr_sel,
   output logic                        xfer_req,
   output logic                        req_pend,
   input  logic                        xfer_done,
   output logic                        irq_flag,
   input  logic                        irq_clr,
   input  logic                        rd_en,
   output logic [8*WORD_BYTES-1:0]     rd_word,
   output logic                        full,
   output logic                        empty,
   output logic [$clog2(DEPTH+1)-1:0]  level
);
   generate
      if (THR_HI > DEPTH) begin : g_bad_cfg
         $error("rxq_ctrl: threshold exceeds queue depth");
      end
   endgenerate

   logic stall;
   logic cap;

   assign in_ready = !full && !stall;
   assign cap      = in_valid && in_ready;

   rxq_store #(
      .DEPTH      (DEPTH),
      .WORD_BYTES (WORD_BYTES),
      .BIG_END    (BIG_END)
   ) u_store (
      .clk       (clk),
      .rst       (rst),
      .push      (cap),
      .push_byte (in_byte),
      .pop       (rd_en),
      .word      (rd_word),
      .full      (full),
      .empty     (empty),
      .level     (level)
   );

   rxq_reqfsm #(
      .THR_LO (THR_LO),
      .THR_HI (THR_HI)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .cap      (cap),
      .thr_sel  (thr_sel),
      .done     (xfer_done),
      .irq_clr  (irq_clr),
      .stall    (stall),
      .xfer_req (xfer_req),
      .req_pend (req_pend),
      .irq_flag (irq_flag)
   );

   // R3
   empty_full_chk: assert property (@(posedge clk) disable iff (rst)
      !(empty && full));
endmodule

// File: tb/rxq_ctrl_bench.sv
module rxq_ctrl_bench;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  in_byte = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        thr_sel = 1'b0;
   logic        xfer_req;
   logic        req_pend;
   logic        xfer_done = 1'b0;
   logic        irq_flag;
   logic        irq_clr = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_word;
   logic        full;
   logic        empty;
   logic [8:0]  level;

   int n_chk = 0;
   int n_bad = 0;
   int n_req = 0;
   logic [7:0] exp_q [$];
   logic [7:0] seed = 8'h11;

   always #(CLK_NS/2) clk = ~clk;

   rxq_ctrl u_rxq_ctrl (
      .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
      .in_ready(in_ready), .thr_sel(thr_sel), .xfer_req(xfer_req),
      .req_pend(req_pend), .xfer_done(xfer_done), .irq_flag(irq_flag),
      .irq_clr(irq_clr), .rd_en(rd_en), .rd_word(rd_word), .full(full),
      .empty(empty), .level(level)
   );

   always @(posedge clk) if (!rst && xfer_req) n_req++;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // driver: offer one byte for one cycle; scoreboard records it if accepted
   task automatic send_byte(input logic [7:0] b);
      in_byte  = b;
      in_valid = 1'b1;
      if (in_ready) exp_q.push_back(b);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_n(input int n);
      for (int i = 0; i < n; i++) begin
         seed = seed * 8'd5 + 8'd3;
         send_byte(seed);
      end
   endtask

   task automatic pulse_done();
      xfer_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   // monitor: compare the word on the read port against the scoreboard, then pop
   task automatic pop_word();
      logic [31:0] exp_w;
      exp_w = '0;
      for (int i = 0; i < 4; i++) exp_w[i*8 +: 8] = exp_q.pop_front();
      chk(rd_word == exp_w, "R2", rd_word, exp_w);
      rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int req0;
      int lv;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1
      chk(empty && !full && level == 0, "R1", level, 0);
      chk(!xfer_req && !req_pend && !irq_flag && in_ready, "R1",
          {xfer_req, req_pend, irq_flag, in_ready}, 4'b0001);

      // R4 / R3: 31 bytes give no request, the 32nd gives one
      thr_sel = 1'b0;
      send_n(31);
      chk(n_req == 0 && !xfer_req, "R4", n_req, 0);
      chk(level == 31 && !empty, "R3", level, 31);
      send_n(1);
      chk(xfer_req == 1'b1, "R4", xfer_req, 1);
      chk(req_pend && irq_flag, "R7", {req_pend, irq_flag}, 2'b11);
      @(negedge clk);
      chk(!xfer_req && n_req == 1, "R4", n_req, 1);

      // R6: sticky until cleared
      chk(irq_flag, "R6", irq_flag, 1);
      pulse_clr();
      chk(!irq_flag, "R6", irq_flag, 0);

      // R7 / R8: second threshold while pending stalls intake
      send_n(31);
      chk(in_ready && level == 63, "R7", level, 63);
      send_n(1);
      chk(!in_ready && n_req == 1, "R8", {in_ready, 8'(n_req)}, 9'h001);
      send_n(3);
      chk(level == 64, "R8", level, 64);
      pulse_done();
      chk(xfer_req && in_ready && req_pend, "R8",
          {xfer_req, in_ready, req_pend}, 3'b111);
      chk(irq_flag, "R6", irq_flag, 1);

      // R9: done with count below threshold ends pending state
      pulse_done();
      chk(!req_pend && !xfer_req, "R9", {req_pend, xfer_req}, 2'b00);

      // R10: done while idle is ignored
      pulse_clr();
      req0 = n_req;
      pulse_done();
      chk(!req_pend && !xfer_req && !irq_flag, "R10",
          {req_pend, xfer_req, irq_flag}, 3'b000);
      @(negedge clk);
      chk(n_req == req0, "R10", n_req, req0);

      // R2: drain, then a pop with an empty queue is ignored
      while (exp_q.size() >= 4) pop_word();
      chk(empty && level == 0, "R2", level, 0);
      rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      chk(level == 0, "R2", level, 0);

      // R5: 64-byte threshold
      thr_sel = 1'b1;
      req0 = n_req;
      send_n(32);
      @(negedge clk);
      chk(n_req == req0, "R5", n_req, req0);
      send_n(31);
      chk(!xfer_req, "R5", xfer_req, 0);
      send_n(1);
      chk(xfer_req, "R5", xfer_req, 1);

      // R11: fill to full, releasing stalls with done
      while (!full) begin
         if (!in_ready) pulse_done();
         else send_n(1);
      end
      chk(level == 256 && !in_ready, "R11", level, 256);
      send_n(2);
      chk(level == 256 && exp_q.size() == 256, "R11", level, 256);
      pop_word();
      chk(!full && level == 252, "R11", level, 252);
      while (exp_q.size() >= 4) pop_word();
      chk(empty, "R2", level, 0);

      // R12: reset during activity
      if (req_pend) pulse_done();
      thr_sel = 1'b0;
      send_n(40);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      exp_q.delete();
      lv = int'(level);
      chk(lv == 0 && empty && !req_pend && !xfer_req && !irq_flag, "R12", lv, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule